// File: doc/BRIEF.md
# Transmitter Power-Domain Enable Controller

This block decides, every clock cycle, which power domains of a mixed-signal transmitter are switched on. There are seven domain enables: the digital core, the DAC digital logic, the DAC bias and analog section, the PLL, the oscillator, the clock input, and the clock gate of the keying function. All of them are active high. Three kinds of request can turn a domain off. Software power-down bits give direct control. An external power-down pin has a selectable depth: in light mode only the digital logic sleeps, and in deep mode every domain sleeps. An idle timer turns the digital logic off after transmit enable has stayed low for a programmed number of cycles.

The configuration bits and the idle limit are static inputs that stand for programmed register fields. The external pin and transmit enable are asynchronous. Each passes through a two-flop synchronizer before it is used. A lock input stands in for the PLL. After a deep power-down the `ready` output is held low until that lock input is high.

Top module: `pwr_dom_ctrl`

## Requirements
- R1: Software bits are active high. `sw_pd_core` clears `en_core`. `sw_pd_dac` clears `en_dac_dig` and `en_dac_bias`. `sw_pd_clkin` clears `en_clkin`. With all three at 0, none of these domains is turned off by software.
- R2: `ext_pd_pin` and `tx_en` are each sampled by two flops. A change driven between two rising edges shows up at the outputs only after the second rising edge that follows it.
- R3: In light pin mode (`pin_deep` = 0), a synchronized high pin clears `en_core` and `en_dac_dig`. It leaves `en_dac_bias`, `en_pll`, `en_osc` and `en_clkin` high.
- R4: In deep pin mode (`pin_deep` = 1), a synchronized high pin clears all seven domain enables.
- R5: With `auto_pd_en` = 1, the idle power-down asserts once the synchronized `tx_en` has been sampled low on `idle_limit` consecutive rising edges (`idle_limit` ≥ 1). It clears `en_core` and `en_dac_dig`. With `auto_pd_en` = 0, the idle timer has no effect.
- R6: A synchronized high `tx_en` clears the idle count. It ends idle power-down on the following rising edge. A new low period counts from zero.
- R7: `en_keying_clk` is high only when `keying_en` = 1 and `en_core` is high.
- R8: `ready` is a registered output. It is low in the cycle after any pin or idle power-down request is seen. After a light-mode pin power-down, it returns high on the first rising edge after the synchronized pin falls.
- R9: After a deep-mode pin power-down, `ready` stays low until `pll_lock` is sampled high on a rising edge with no request active. It rises on that edge.
- R10: Reset (active-low `rst_n`) clears both synchronizers, the idle state, the lock-wait state and `ready`. With no request active, `ready` rises on the first rising edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_pd_core | input | 1 | Software power-down of the digital core |
| sw_pd_dac | input | 1 | Software power-down of the DAC (digital and bias) |
| sw_pd_clkin | input | 1 | Software power-down of the clock input |
| pin_deep | input | 1 | Pin depth: 0 light, 1 deep |
| auto_pd_en | input | 1 | Enables idle power-down |
| keying_en | input | 1 | Enables the keying function clock |
| idle_limit | input | CW | Idle cycles before idle power-down |
| ext_pd_pin | input | 1 | Asynchronous external power-down request |
| tx_en | input | 1 | Asynchronous transmit enable |
| pll_lock | input | 1 | PLL lock indication |
| en_core | output | 1 | Digital core enable |
| en_dac_dig | output | 1 | DAC digital logic enable |
| en_dac_bias | output | 1 | DAC bias and analog enable |
| en_pll | output | 1 | PLL enable |
| en_osc | output | 1 | Oscillator enable |
| en_clkin | output | 1 | Clock input enable |
| en_keying_clk | output | 1 | Keying function clock gate enable |
| ready | output | 1 | All requested domains powered and ready |

## Verification
The static mapping is swept over every combination of the three software bits, the keying bit, the pin depth and the pin level. Each of the 64 combinations is compared with an arithmetic model, so any request routed to the wrong domain is exposed. The idle timer is swept over several limits, and each run is checked one cycle before and at the expected trip point, which catches off-by-one counting. Separate runs check the following: synchronizer latency, ending idle power-down with `tx_en` and restarting the count, and the ready recovery in light mode compared with deep mode while `pll_lock` is held low.

// File: rtl/pwr_dom_ctrl.sv
module pwr_dom_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_pd_core,
  input  logic          sw_pd_dac,
  input  logic          sw_pd_clkin,
  input  logic          pin_deep,
  input  logic          auto_pd_en,
  input  logic          keying_en,
  input  logic [CW-1:0] idle_limit,
  input  logic          ext_pd_pin,
  input  logic          tx_en,
  input  logic          pll_lock,
  output logic          en_core,
  output logic          en_dac_dig,
  output logic          en_dac_bias,
  output logic          en_pll,
  output logic          en_osc,
  output logic          en_clkin,
  output logic          en_keying_clk,
  output logic          ready
);

  logic [1:0]    pin_sync, tx_sync;
  logic          pin_s, tx_s;
  logic          idle;
  logic [CW-1:0] idle_cnt;
  logic          auto_pd, deep_pd, lock_wait, lock_wait_n, ready_q;
  logic [1:0]    warm;

  assign pin_s = pin_sync[1];
  assign tx_s  = tx_sync[1];

  // R2: two-flop synchronizers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sync <= '0;
      tx_sync  <= '0;
    end else begin
      pin_sync <= {pin_sync[0], ext_pd_pin};
      tx_sync  <= {tx_sync[0], tx_en};
    end
  end

  // R5, R6: idle timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle     <= 1'b0;
      idle_cnt <= '0;
    end else if (!auto_pd_en || tx_s) begin
      idle     <= 1'b0;
      idle_cnt <= '0;
    end else begin
      idle <= 1'b1;
      if (idle_cnt != idle_limit) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign auto_pd = idle && (idle_cnt == idle_limit);
  assign deep_pd = pin_s && pin_deep;

  assign en_core       = !(sw_pd_core | pin_s | auto_pd);
  assign en_dac_dig    = !(sw_pd_dac | pin_s | auto_pd);
  assign en_dac_bias   = !(sw_pd_dac | deep_pd);
  assign en_pll        = !deep_pd;
  assign en_osc        = !deep_pd;
  assign en_clkin      = !(sw_pd_clkin | deep_pd);
  assign en_keying_clk = keying_en & en_core;

  // R8, R9: ready and lock wait
  assign lock_wait_n = deep_pd | (lock_wait & ~pll_lock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_wait <= 1'b0;
      ready_q   <= 1'b0;
      warm      <= '0;
    end else begin
      lock_wait <= lock_wait_n;
      ready_q   <= !(pin_s | auto_pd) && !lock_wait_n;
      if (warm != 2'd3) warm <= warm + 1'b1;
    end
  end

  assign ready = ready_q;

  assert_sw_core_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pd_core |-> (!en_core && !en_keying_clk));

  assert_deep_pin_kills_pll_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && $past(ext_pd_pin, 2) && pin_deep) |-> (!en_pll && !en_osc && !en_dac_bias));

  assert_light_keeps_clocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_deep && !sw_pd_clkin) |-> (en_clkin && en_osc && en_pll));

  assert_tx_ends_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_s) && !sw_pd_core && !pin_s) |-> en_core);

  assert_ready_after_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd1 && ready && !$past(ready) && $past(lock_wait)) |-> $past(pll_lock));

endmodule

// File: tb/sim_pwr_dom_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_dom_ctrl;
  localparam int CW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_pd_core = 0, sw_pd_dac = 0, sw_pd_clkin = 0, pin_deep = 0;
  logic auto_pd_en = 0, keying_en = 1, ext_pd_pin = 0, tx_en = 1, pll_lock = 1;
  logic [CW-1:0] idle_limit = 8'd3;
  logic en_core, en_dac_dig, en_dac_bias, en_pll, en_osc, en_clkin, en_keying_clk, ready;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  pwr_dom_ctrl #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_pd_core(sw_pd_core), .sw_pd_dac(sw_pd_dac),
    .sw_pd_clkin(sw_pd_clkin), .pin_deep(pin_deep), .auto_pd_en(auto_pd_en),
    .keying_en(keying_en), .idle_limit(idle_limit), .ext_pd_pin(ext_pd_pin),
    .tx_en(tx_en), .pll_lock(pll_lock), .en_core(en_core), .en_dac_dig(en_dac_dig),
    .en_dac_bias(en_dac_bias), .en_pll(en_pll), .en_osc(en_osc), .en_clkin(en_clkin),
    .en_keying_clk(en_keying_clk), .ready(ready));

  function automatic logic [7:0] outs();
    return {en_core, en_dac_dig, en_dac_bias, en_pll, en_osc, en_clkin, en_keying_clk, ready};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] e;
    logic c, d, k, p, pk;
    waitn(2);
    chk("R10 ready low in reset", {7'b0, ready}, 8'd0);
    rst_n = 1'b1;
    waitn(1);
    chk("R10 state after first edge", outs(), 8'hFF);

    // R1 R3 R4 R7: exhaustive static sweep
    for (int v = 0; v < 64; v++) begin
      c = v[0]; d = v[1]; k = v[2]; pk = v[3]; pin_deep = v[4]; p = v[5];
      sw_pd_core = c; sw_pd_dac = d; sw_pd_clkin = k; keying_en = pk; ext_pd_pin = p;
      waitn(3);
      e[7] = !(c | p);
      e[6] = !(d | p);
      e[5] = !(d | (p & pin_deep));
      e[4] = !(p & pin_deep);
      e[3] = !(p & pin_deep);
      e[2] = !(k | (p & pin_deep));
      e[1] = pk & e[7];
      e[0] = !p;
      chk($sformatf("R1 R3 R4 R7 sweep v=%0d", v), outs(), e);
    end
    ext_pd_pin = 0; sw_pd_core = 0; sw_pd_dac = 0; sw_pd_clkin = 0; keying_en = 1; pin_deep = 0;
    waitn(3);

    // R2: synchronizer latency
    ext_pd_pin = 1;
    waitn(1);
    chk("R2 pin not yet seen", {7'b0, en_core}, 8'd1);
    waitn(1);
    chk("R2 pin seen after two edges", {7'b0, en_core}, 8'd0);
    // R8 light recovery
    waitn(2);
    ext_pd_pin = 0;
    waitn(2);
    chk("R8 ready still low", {7'b0, ready}, 8'd0);
    waitn(1);
    chk("R8 ready back next edge", {7'b0, ready}, 8'd1);

    // R9 deep recovery waits for lock
    pin_deep = 1; pll_lock = 0; ext_pd_pin = 1;
    waitn(3);
    ext_pd_pin = 0;
    waitn(6);
    chk("R9 ready held without lock", {en_pll, 6'b0, ready}, 8'h80);
    pll_lock = 1;
    waitn(1);
    chk("R9 ready after lock", {7'b0, ready}, 8'd1);
    pin_deep = 0;

    // R5 disabled: tx low has no effect
    tx_en = 0;
    waitn(12);
    chk("R5 auto disabled no effect", outs(), 8'hFF);
    tx_en = 1;
    waitn(3);

    // R5 R6: idle limit sweep
    auto_pd_en = 1;
    for (int L = 1; L <= 6; L++) begin
      idle_limit = CW'(L);
      waitn(2);
      tx_en = 0;
      waitn(L + 1);
      chk($sformatf("R5 L=%0d one before trip", L), {7'b0, en_core}, 8'd1);
      waitn(1);
      chk($sformatf("R5 L=%0d trip", L), {en_core, en_dac_dig, en_dac_bias, en_pll, 4'b0}, 8'h30);
      waitn(1);
      chk($sformatf("R8 L=%0d ready low idle", L), {7'b0, ready}, 8'd0);
      tx_en = 1;
      waitn(2);
      chk($sformatf("R6 L=%0d still idle", L), {7'b0, en_core}, 8'd0);
      waitn(1);
      chk($sformatf("R6 L=%0d exit", L), {7'b0, en_core}, 8'd1);
      waitn(1);
      chk($sformatf("R8 L=%0d ready back", L), {7'b0, ready}, 8'd1);
    end

    // R6: count restarts after a short high pulse
    idle_limit = 8'd4;
    tx_en = 0;
    waitn(4);
    tx_en = 1;
    waitn(1);
    tx_en = 0;
    waitn(5);
    chk("R6 count restarted", {7'b0, en_core}, 8'd1);
    waitn(1);
    chk("R6 trip after restart", {7'b0, en_core}, 8'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule